// File: doc/BRIEF.md
# Shared Bus Register Datapath

This block is the data path of a small accumulator machine. A single 16-bit bus connects six registers and a 4096-word by 16-bit memory. A 3-bit source code decides which one item drives the bus in a cycle. The six registers are an address register, a program counter, a data register, an accumulator, an instruction register and a scratch register. The memory is always addressed by the address register. It can place the addressed word on the bus, or store the current bus value.

Each register has three synchronous controls: clear, load and increment. A sequencer outside the block drives these strobes, the source code and the memory write enable. The arithmetic unit is also outside the block. Its result enters through `alu_res`, and that input is what the accumulator loads. Every enabled transfer completes on the same rising edge. Because of this, a single cycle can move the accumulator into the data register while the accumulator takes the old data-register value back through the arithmetic path. The block has no streaming data interface, so every pin is a plain level-sensitive control or data line.

Top module: `bus_datapath`

## Requirements
- R1: `bus_sel` picks the bus source with this encoding: 000 gives zero, 001 the address register, 010 the program counter, 011 the data register, 100 the accumulator, 101 the instruction register, 110 the scratch register, and 111 the memory word at the address register.
- R2: When a 12-bit register (address register or program counter) drives the bus, bus bits 15..12 read zero.
- R3: When a 12-bit register loads, it takes bus bits 11..0. A 16-bit register other than the accumulator takes the whole bus.
- R4: Within one register, clear overrides load, and load overrides increment.
- R5: An increment wraps to zero: from 0xFFF for the 12-bit registers and from 0xFFFF for the 16-bit registers.
- R6: When `mem_wr` is high, the memory stores the bus value present before the edge at the address-register value present before the edge. This holds even if the address register loads in the same cycle. A later read with code 111 returns the stored word.
- R7: An accumulator load takes `alu_res`, not the bus.
- R8: All enabled transfers share one edge. With code 100, a data-register load and an accumulator load in the same cycle exchange the two values, provided `alu_res` carries the old data-register value.
- R9: While `rst_n` is low, all six registers read zero.
- R10: A register with no control asserted keeps its value.

Register strobe vectors use this bit index: 0 address register, 1 program counter, 2 data register, 3 accumulator, 4 instruction register, 5 scratch register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the registers |
| bus_sel | input | 3 | Bus source code |
| reg_ld | input | 6 | Per-register load strobes |
| reg_inr | input | 6 | Per-register increment strobes |
| reg_clr | input | 6 | Per-register clear strobes |
| mem_wr | input | 1 | Store the bus into memory at the address register |
| alu_res | input | 16 | Arithmetic-path result, loaded by the accumulator |
| bus_out | output | 16 | Current bus value |
| ar_q | output | 12 | Address register |
| pc_q | output | 12 | Program counter |
| dr_q | output | 16 | Data register |
| ac_q | output | 16 | Accumulator |
| ir_q | output | 16 | Instruction register |
| tr_q | output | 16 | Scratch register |

## Verification
The memory store and a load of the address register can fall in the same cycle. The bench provokes this by driving the accumulator onto the bus with `mem_wr` and the address-register load both high. It then points the address register back to the old address and reads with code 111, which must return the value that was on the bus before the edge. The data-register and accumulator loads can also share an edge. The bench drives code 100 with both loads set and `alu_res` equal to the old data register, and it expects the two values to come back exchanged.

// File: rtl/bus_pkg.sv
package bus_pkg;
  localparam int NREG = 6;
  localparam int IX_AR = 0;
  localparam int IX_PC = 1;
  localparam int IX_DR = 2;
  localparam int IX_AC = 3;
  localparam int IX_IR = 4;
  localparam int IX_TR = 5;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AR   = 3'd1,
    SRC_PC   = 3'd2,
    SRC_DR   = 3'd3,
    SRC_AC   = 3'd4,
    SRC_IR   = 3'd5,
    SRC_TR   = 3'd6,
    SRC_MEM  = 3'd7
  } bus_src_e;
endpackage

// File: rtl/bus_reg.sv
module bus_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic         inr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (ld)  q <= d;
    else if (inr) q <= q + 1'b1;
  end

  assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  assert_load_over_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !clr) |=> (q == $past(d)));
  assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inr && !ld && !clr) |=> (q == W'($past(q) + 1'b1)));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!inr && !ld && !clr) |=> $stable(q));
endmodule

// File: rtl/bus_mux.sv
module bus_mux
  import bus_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic [2:0]        sel,
  input  logic [ADDR_W-1:0] ar,
  input  logic [ADDR_W-1:0] pc,
  input  logic [BUS_W-1:0]  dr,
  input  logic [BUS_W-1:0]  ac,
  input  logic [BUS_W-1:0]  ir,
  input  logic [BUS_W-1:0]  tr,
  input  logic [BUS_W-1:0]  mem_rd,
  output logic [BUS_W-1:0]  bus
);
  localparam int PAD_W = BUS_W - ADDR_W;

  always_comb begin
    unique case (bus_src_e'(sel))
      SRC_AR:  bus = {{PAD_W{1'b0}}, ar};
      SRC_PC:  bus = {{PAD_W{1'b0}}, pc};
      SRC_DR:  bus = dr;
      SRC_AC:  bus = ac;
      SRC_IR:  bus = ir;
      SRC_TR:  bus = tr;
      SRC_MEM: bus = mem_rd;
      default: bus = '0;
    endcase
  end
endmodule

// File: rtl/bus_mem.sv
module bus_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];

  assert_store_pre_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cells[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/bus_datapath.sv
module bus_datapath
  import bus_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_sel,
  input  logic [NREG-1:0]   reg_ld,
  input  logic [NREG-1:0]   reg_inr,
  input  logic [NREG-1:0]   reg_clr,
  input  logic              mem_wr,
  input  logic [BUS_W-1:0]  alu_res,
  output logic [BUS_W-1:0]  bus_out,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [BUS_W-1:0]  dr_q,
  output logic [BUS_W-1:0]  ac_q,
  output logic [BUS_W-1:0]  ir_q,
  output logic [BUS_W-1:0]  tr_q
);
  localparam int NNARROW = 2;
  localparam int NWIDE   = NREG - NNARROW;

  logic [BUS_W-1:0]  bus;
  logic [BUS_W-1:0]  mem_rd;
  logic [ADDR_W-1:0] nq [NNARROW];
  logic [BUS_W-1:0]  wq [NWIDE];

  genvar gi;
  generate
    for (gi = 0; gi < NNARROW; gi++) begin : g_narrow
      bus_reg #(.W(ADDR_W)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[gi]), .ld(reg_ld[gi]), .inr(reg_inr[gi]),
        .d(bus[ADDR_W-1:0]), .q(nq[gi])
      );
    end
    for (gi = 0; gi < NWIDE; gi++) begin : g_wide
      localparam int IDX = gi + NNARROW;
      logic [BUS_W-1:0] din;
      if (IDX == IX_AC) begin : g_alu_src
        assign din = alu_res;
      end else begin : g_bus_src
        assign din = bus;
      end
      bus_reg #(.W(BUS_W)) u_reg (
        .clk(clk), .rst_n(rst_n),
        .clr(reg_clr[IDX]), .ld(reg_ld[IDX]), .inr(reg_inr[IDX]),
        .d(din), .q(wq[gi])
      );
    end
  endgenerate

  assign ar_q = nq[IX_AR];
  assign pc_q = nq[IX_PC];
  assign dr_q = wq[IX_DR - NNARROW];
  assign ac_q = wq[IX_AC - NNARROW];
  assign ir_q = wq[IX_IR - NNARROW];
  assign tr_q = wq[IX_TR - NNARROW];

  bus_mux #(.BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_mux (
    .sel(bus_sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
    .ir(ir_q), .tr(tr_q), .mem_rd(mem_rd), .bus(bus)
  );

  bus_mem #(.DATA_W(BUS_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_wr), .addr(ar_q),
    .wdata(bus), .rdata(mem_rd)
  );

  assign bus_out = bus;

  assert_narrow_pad_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SRC_AR || bus_sel == SRC_PC) |-> (bus[BUS_W-1:ADDR_W] == '0));
  assert_acc_from_alu_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_ld[IX_AC] && !reg_clr[IX_AC]) |=> (ac_q == $past(alu_res)));
  assert_swap_same_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SRC_AC && reg_ld[IX_DR] && reg_ld[IX_AC] &&
     !reg_clr[IX_DR] && !reg_clr[IX_AC])
    |=> (dr_q == $past(ac_q)) && (ac_q == $past(alu_res)));
endmodule

// File: tb/sim_bus_datapath.sv
module sim_bus_datapath;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic [5:0]  reg_ld = '0, reg_inr = '0, reg_clr = '0;
  logic        mem_wr = 1'b0;
  logic [15:0] alu_res = '0;
  logic [15:0] bus_out;
  logic [11:0] ar_q, pc_q;
  logic [15:0] dr_q, ac_q, ir_q, tr_q;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct packed {
    logic [5:0][15:0] r;
    logic [7:0]       req;
  } exp_t;

  exp_t        expq [$];
  logic [15:0] m [6];
  logic [15:0] mm [int];

  always #4 clk = ~clk;

  bus_datapath u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .reg_ld(reg_ld),
    .reg_inr(reg_inr), .reg_clr(reg_clr), .mem_wr(mem_wr), .alu_res(alu_res),
    .bus_out(bus_out), .ar_q(ar_q), .pc_q(pc_q), .dr_q(dr_q), .ac_q(ac_q),
    .ir_q(ir_q), .tr_q(tr_q)
  );

  function automatic logic [15:0] model_bus(input logic [2:0] s);
    case (s)
      3'd1: return {4'h0, m[0][11:0]};
      3'd2: return {4'h0, m[1][11:0]};
      3'd3: return m[2];
      3'd4: return m[3];
      3'd5: return m[4];
      3'd6: return m[5];
      3'd7: return mm.exists(int'(m[0][11:0])) ? mm[int'(m[0][11:0])] : 16'h0;
      default: return 16'h0;
    endcase
  endfunction

  task automatic push_model(input int req);
    exp_t e;
    for (int i = 0; i < 6; i++) e.r[i] = m[i];
    e.req = 8'(req);
    expq.push_back(e);
  endtask

  // Driver: applies one cycle of controls, checks the bus, predicts the edge.
  task automatic step(input logic [2:0] s, input logic [5:0] ld, input logic [5:0] inr,
                      input logic [5:0] clr, input logic wr, input logic [15:0] alu,
                      input int req);
    logic [15:0] b;
    logic [15:0] mask;
    @(negedge clk);
    bus_sel = s; reg_ld = ld; reg_inr = inr; reg_clr = clr; mem_wr = wr; alu_res = alu;
    #1;
    b = model_bus(s);
    checks++;
    if (bus_out !== b) begin
      fails++;
      $display("FAIL R1 bus sel=%0d req R%0d: actual %h expected %h", s, req, bus_out, b);
    end
    if (wr) mm[int'(m[0][11:0])] = b;
    for (int i = 0; i < 6; i++) begin
      mask = (i < 2) ? 16'h0FFF : 16'hFFFF;
      if (clr[i])      m[i] = 16'h0;
      else if (ld[i])  m[i] = ((i == 3) ? alu : b) & mask;
      else if (inr[i]) m[i] = (m[i] + 16'h1) & mask;
    end
    push_model(req);
  endtask

  // Monitor: compares registers shortly after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expq.size() > 0) begin
        exp_t e;
        logic [5:0][15:0] a;
        e = expq.pop_front();
        a[0] = {4'h0, ar_q}; a[1] = {4'h0, pc_q};
        a[2] = dr_q; a[3] = ac_q; a[4] = ir_q; a[5] = tr_q;
        checks++;
        if (a !== e.r) begin
          fails++;
          $display("FAIL R%0d regs: actual %h expected %h", e.req, a, e.r);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) m[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    push_model(9);                                            // R9 reset state
    step(3'd0, 6'b001000, 0, 0, 0, 16'hBEEF, 7);              // R7 AC from alu
    step(3'd4, 6'b000001, 0, 0, 0, 16'h0, 3);                 // R3 AR takes low bits
    step(3'd1, 6'b000010, 0, 0, 0, 16'h0, 2);                 // R2 AR on bus padded
    step(3'd0, 6'b001000, 0, 0, 0, 16'h1234, 7);              // R7
    step(3'd4, 6'b010100, 0, 0, 0, 16'h0, 3);                 // R3 DR and IR load
    step(3'd3, 6'b100000, 0, 0, 0, 16'h0, 1);                 // R1 DR source
    step(3'd5, 6'b000000, 0, 0, 0, 16'h0, 1);                 // R1 IR source
    step(3'd6, 6'b000000, 0, 0, 0, 16'h0, 1);                 // R1 TR source
    step(3'd2, 6'b000000, 0, 0, 0, 16'h0, 2);                 // R2 PC on bus padded
    step(3'd4, 6'b000001, 0, 0, 1, 16'h0, 6);                 // R6 store with AR load
    step(3'd2, 6'b000001, 0, 0, 0, 16'h0, 6);                 // R6 AR back to old addr
    step(3'd0, 0, 0, 6'b000100, 0, 16'h0, 4);                 // R4 clear DR
    step(3'd7, 6'b000100, 0, 0, 0, 16'h0, 6);                 // R6 read stored word
    step(3'd0, 6'b100000, 6'b100000, 6'b100000, 0, 16'h0, 4); // R4 clear wins
    step(3'd4, 6'b100000, 6'b100000, 0, 0, 16'h0, 4);         // R4 load over inc
    step(3'd0, 0, 6'b100000, 0, 0, 16'h0, 4);                 // R4 inc alone
    step(3'd0, 6'b001000, 0, 0, 0, 16'hFFFF, 7);              // R7
    step(3'd4, 6'b100010, 0, 0, 0, 16'h0, 3);                 // R3 PC=FFF TR=FFFF
    step(3'd0, 0, 6'b100010, 0, 0, 16'h0, 5);                 // R5 both wrap
    step(3'd4, 6'b001100, 0, 0, 0, m[2], 8);                  // R8 swap DR/AC
    step(3'd3, 0, 0, 0, 0, 16'h0, 10);                        // R10 hold
    step(3'd0, 0, 0, 0, 0, 16'h0, 10);                        // R10 hold
    step(3'd6, 0, 0, 0, 0, 16'h0, 10);                        // R10 hold
    @(negedge clk);
    bus_sel = '0; reg_ld = '0; reg_inr = '0; reg_clr = '0; mem_wr = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule